// File: doc/BRIEF.md
# Navigation Data Code Mixer

This block puts a slow navigation data stream onto spreading-code chips and hands baseband sign streams to two carrier modulators. Each chip is exclusive-ored with the data bit that is current. This is the same as multiplying two signs, with logic 0 as +1 and logic 1 as -1. The clock runs at the precision chip rate. Coarse chips are presented on the same clock and are held by the source for as many clocks as one coarse chip lasts.

For the first carrier the block drives two outputs. The precision stream goes on the in-phase output and the coarse stream on the quadrature output. A per-channel weight flag marks the precision component as the weaker one, 3 dB down. For the second carrier a mode input selects one of three streams, so the two codes never appear together there. Data bits are pulled from a ready/valid source only when a counter of coarse-code epoch pulses wraps, once every 20 epochs. Data edges therefore always fall on chip edges, at 50 bps for a 1 kHz epoch rate.

Top module: `nav_code_mixer`

## Requirements
- R1: While rst_ni is low, every output is 0, including bit_ready_o.
- R2: l1_i_o equals p_chip_i XOR the current data bit, registered with a latency of one clock.
- R3: l1_q_o equals ca_chip_i XOR the current data bit, with a latency of one clock.
- R4: From the first clock after reset, l1_i_wt_o is 1 (the precision channel is 3 dB weaker) and l1_q_wt_o is 0.
- R5: bit_ready_o is high only in a cycle where ca_epoch_i is high and 19 epoch pulses have been seen since reset or since the last wrap. That cycle is the wrap.
- R6: A bit accepted at a wrap applies to the chips presented in the wrap cycle itself. data_strobe_o pulses for one clock, in the same cycle as the first output that carries the new bit.
- R7: If bit_valid_i is low at a wrap, the previous data bit is repeated and underrun_o goes to 1. underrun_o holds that value until the next wrap, and is cleared by a wrap where a bit is accepted. The data bit after reset is 0.
- R8: mode_i = 2'b00 drives l2_o with p_chip_i XOR data.
- R9: mode_i = 2'b01 drives l2_o with p_chip_i alone.
- R10: mode_i = 2'b10 drives l2_o with ca_chip_i XOR data.
- R11: mode_i = 2'b11 is reserved and behaves exactly like 2'b00.
- R12: bit_valid_i and bit_data_i have no effect outside a wrap cycle. No bit is consumed and the data bit does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Precision chip-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| p_chip_i | input | 1 | Precision-code chip |
| ca_chip_i | input | 1 | Coarse-code chip |
| ca_epoch_i | input | 1 | One-clock pulse on the first chip of each coarse-code period |
| bit_data_i | input | 1 | Navigation data bit from the source |
| bit_valid_i | input | 1 | Source has a bit available |
| bit_ready_o | output | 1 | Bit taken this cycle (wrap) |
| mode_i | input | 2 | Second-carrier stream select |
| l1_i_o | output | 1 | First carrier in-phase sign (precision XOR data) |
| l1_q_o | output | 1 | First carrier quadrature sign (coarse XOR data) |
| l1_i_wt_o | output | 1 | In-phase weight flag, 1 = attenuated |
| l1_q_wt_o | output | 1 | Quadrature weight flag, 1 = attenuated |
| l2_o | output | 1 | Second carrier sign |
| data_strobe_o | output | 1 | One-clock pulse when a new data period starts |
| underrun_o | output | 1 | Last wrap found no valid bit |

## Verification
The hardest condition to reach is a wrap that finds no valid bit while the stream is running. It must be followed by a wrap that does accept one, so that the repeated bit, the held flag and its clearing are all observed. The stimulus fires epoch pulses densely and drops bit_valid_i at random, so that a wrap arrives every few dozen clocks and many underrun and recovery pairs occur. valid is also raised between wraps to show that it is ignored there. Modes, including the reserved code, change at random during the same run.

// File: rtl/nav_mix_pkg.sv
package nav_mix_pkg;
  typedef enum logic [1:0] {
    L2_P_DATA  = 2'b00,
    L2_P_ONLY  = 2'b01,
    L2_CA_DATA = 2'b10,
    L2_RSVD    = 2'b11
  } l2_mode_e;

  localparam int unsigned DEF_EPOCHS_PER_BIT = 20;
endpackage

// File: rtl/nav_bit_timer.sv
module nav_bit_timer #(
  parameter int unsigned EPOCHS_PER_BIT = nav_mix_pkg::DEF_EPOCHS_PER_BIT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic epoch_i,
  output logic wrap_o
);
  localparam int unsigned CW = (EPOCHS_PER_BIT > 1) ? $clog2(EPOCHS_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(EPOCHS_PER_BIT - 1);

  logic [CW-1:0] cnt_q;

  assign wrap_o = epoch_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else if (epoch_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/nav_bit_latch.sv
module nav_bit_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_i,
  input  logic bit_data_i,
  input  logic bit_valid_i,
  output logic bit_ready_o,
  output logic data_cur_o,
  output logic strobe_o,
  output logic underrun_o
);
  logic data_q;
  logic take;

  assign bit_ready_o = wrap_i;
  assign take        = wrap_i && bit_valid_i;
  // new bit applies to the chip of the wrap cycle itself
  assign data_cur_o  = take ? bit_data_i : data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q     <= 1'b0;
      strobe_o   <= 1'b0;
      underrun_o <= 1'b0;
    end else begin
      data_q   <= data_cur_o;
      strobe_o <= wrap_i;
      if (wrap_i) underrun_o <= !bit_valid_i;
    end
  end
endmodule

// File: rtl/nav_chip_mixer.sv
module nav_chip_mixer
  import nav_mix_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       p_chip_i,
  input  logic       ca_chip_i,
  input  logic       data_i,
  input  logic [1:0] mode_i,
  output logic       l1_i_o,
  output logic       l1_q_o,
  output logic       l1_i_wt_o,
  output logic       l1_q_wt_o,
  output logic       l2_o
);
  logic p_mix, ca_mix, l2_d;

  assign p_mix  = p_chip_i ^ data_i;
  assign ca_mix = ca_chip_i ^ data_i;

  always_comb begin
    unique case (l2_mode_e'(mode_i))
      L2_P_ONLY:  l2_d = p_chip_i;
      L2_CA_DATA: l2_d = ca_mix;
      default:    l2_d = p_mix;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l1_i_o    <= 1'b0;
      l1_q_o    <= 1'b0;
      l2_o      <= 1'b0;
      l1_i_wt_o <= 1'b0;
      l1_q_wt_o <= 1'b0;
    end else begin
      l1_i_o    <= p_mix;
      l1_q_o    <= ca_mix;
      l2_o      <= l2_d;
      l1_i_wt_o <= 1'b1;
      l1_q_wt_o <= 1'b0;
    end
  end
endmodule

// File: rtl/nav_code_mixer.sv
module nav_code_mixer #(
  parameter int unsigned EPOCHS_PER_BIT = nav_mix_pkg::DEF_EPOCHS_PER_BIT
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       p_chip_i,
  input  logic       ca_chip_i,
  input  logic       ca_epoch_i,
  input  logic       bit_data_i,
  input  logic       bit_valid_i,
  output logic       bit_ready_o,
  input  logic [1:0] mode_i,
  output logic       l1_i_o,
  output logic       l1_q_o,
  output logic       l1_i_wt_o,
  output logic       l1_q_wt_o,
  output logic       l2_o,
  output logic       data_strobe_o,
  output logic       underrun_o
);
  logic wrap, data_cur, ready_raw;

  nav_bit_timer #(.EPOCHS_PER_BIT(EPOCHS_PER_BIT)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .epoch_i(ca_epoch_i), .wrap_o(wrap)
  );

  nav_bit_latch u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .wrap_i(wrap),
    .bit_data_i(bit_data_i), .bit_valid_i(bit_valid_i),
    .bit_ready_o(ready_raw), .data_cur_o(data_cur),
    .strobe_o(data_strobe_o), .underrun_o(underrun_o)
  );

  // ready is forced low while reset is held
  assign bit_ready_o = ready_raw && rst_ni;

  nav_chip_mixer u_mixer (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .p_chip_i(p_chip_i), .ca_chip_i(ca_chip_i),
    .data_i(data_cur), .mode_i(mode_i),
    .l1_i_o(l1_i_o), .l1_q_o(l1_q_o),
    .l1_i_wt_o(l1_i_wt_o), .l1_q_wt_o(l1_q_wt_o),
    .l2_o(l2_o)
  );
endmodule

// File: rtl/nav_code_mixer_chk.sv
module nav_code_mixer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       p_chip_i,
  input logic       ca_chip_i,
  input logic       ca_epoch_i,
  input logic       bit_ready_o,
  input logic [1:0] mode_i,
  input logic       l1_i_o,
  input logic       l1_q_o,
  input logic       l1_i_wt_o,
  input logic       l1_q_wt_o,
  input logic       l2_o,
  input logic       data_strobe_o
);
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  // R2
  i_q_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> ((l1_i_o ^ l1_q_o) == $past(p_chip_i ^ ca_chip_i)));

  // R4
  weight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> (l1_i_wt_o && !l1_q_wt_o));

  // R5
  ready_on_epoch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_ready_o |-> ca_epoch_i);

  // R6
  strobe_after_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && data_strobe_o |-> $past(bit_ready_o));

  // R9
  l2_p_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(mode_i) == 2'b01 |-> l2_o == $past(p_chip_i));

  // R10
  l2_ca_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(mode_i) == 2'b10 |-> l2_o == l1_q_o);

  // R8
  l2_p_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(mode_i) == 2'b00 |-> l2_o == l1_i_o);

  // R11
  l2_rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(mode_i) == 2'b11 |-> l2_o == l1_i_o);
endmodule

bind nav_code_mixer nav_code_mixer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .p_chip_i(p_chip_i), .ca_chip_i(ca_chip_i),
  .ca_epoch_i(ca_epoch_i), .bit_ready_o(bit_ready_o), .mode_i(mode_i),
  .l1_i_o(l1_i_o), .l1_q_o(l1_q_o), .l1_i_wt_o(l1_i_wt_o), .l1_q_wt_o(l1_q_wt_o),
  .l2_o(l2_o), .data_strobe_o(data_strobe_o)
);

// File: tb/tb_nav_code_mixer.sv
module tb_nav_code_mixer;
  localparam int EPB = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic p_chip = 0, ca_chip = 0, epoch = 0, bdata = 0, bvalid = 0;
  logic [1:0] mode = 2'b00;
  logic ready, l1i, l1q, iwt, qwt, l2, strobe, underrun;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // model state
  int   m_cnt = 0;
  logic m_data = 0, m_under = 0;
  logic e_l1i = 0, e_l1q = 0, e_l2 = 0, e_strobe = 0;

  always #5 clk = ~clk;

  nav_code_mixer #(.EPOCHS_PER_BIT(EPB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .p_chip_i(p_chip), .ca_chip_i(ca_chip),
    .ca_epoch_i(epoch), .bit_data_i(bdata), .bit_valid_i(bvalid),
    .bit_ready_o(ready), .mode_i(mode), .l1_i_o(l1i), .l1_q_o(l1q),
    .l1_i_wt_o(iwt), .l1_q_wt_o(qwt), .l2_o(l2),
    .data_strobe_o(strobe), .underrun_o(underrun)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic l2_ref(input logic [1:0] md, input logic p, input logic ca,
                                  input logic d);
    case (md)
      2'b01:   return p;           // R9
      2'b10:   return ca ^ d;      // R10
      default: return p ^ d;       // R8, R11
    endcase
  endfunction

  // apply inputs (at negedge), check ready, advance model for the coming edge
  task automatic drive(input logic ep, input logic v, input logic d, input logic [1:0] md,
                       input logic p, input logic ca);
    logic wrap, cur;
    epoch = ep; bvalid = v; bdata = d; mode = md; p_chip = p; ca_chip = ca;
    #1;
    wrap = ep && (m_cnt == EPB - 1);
    chk(wrap ? "R5" : "R12", ready, wrap);
    cur = (wrap && v) ? d : m_data;
    e_l1i = p ^ cur;
    e_l1q = ca ^ cur;
    e_l2 = l2_ref(md, p, ca, cur);
    e_strobe = wrap;
    if (wrap) begin m_cnt = 0; m_under = !v; end
    else if (ep) m_cnt++;
    m_data = cur;
  endtask

  task automatic check_out();
    chk("R2", l1i, e_l1i);
    chk("R3", l1q, e_l1q);
    chk("R8", l2, e_l2);
    chk("R6", strobe, e_strobe);
    chk("R7", underrun, m_under);
    chk("R4", iwt, 1'b1);
    chk("R4", qwt, 1'b0);
  endtask

  task automatic cycle(input logic ep, input logic v, input logic d, input logic [1:0] md,
                       input logic p, input logic ca);
    drive(ep, v, d, md, p, ca);
    @(negedge clk);
    #2;
    check_out();
  endtask

  initial begin
    void'($urandom(32'd1234));
    #23;
    // R1 reset state
    epoch = 1; bvalid = 1; #1;
    chk("R1", ready, 0); chk("R1", l1i, 0); chk("R1", l1q, 0); chk("R1", l2, 0);
    chk("R1", iwt, 0); chk("R1", qwt, 0); chk("R1", strobe, 0); chk("R1", underrun, 0);
    epoch = 0; bvalid = 0;
    @(negedge clk); rst_n = 1'b1;
    #1;
    // directed: 19 epochs with valid high (R12 ignored), then wrap with bit 1
    for (int i = 0; i < EPB - 1; i++) cycle(1, 1, 1, 2'b00, 1, 0);
    cycle(1, 1, 1, 2'b00, 1, 0);            // wrap takes 1: R6
    for (int i = 0; i < 3; i++) cycle(0, 1, 0, 2'b11, 0, 1);  // R11, R12
    // directed underrun: wrap with valid low repeats 1 (R7)
    for (int i = 0; i < EPB; i++) cycle(1, 0, 0, 2'b01, i[0], 1);
    cycle(0, 0, 0, 2'b10, 0, 0);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      cycle(($urandom % 3) == 0, ($urandom % 4) != 0, $urandom % 2,
            2'($urandom % 4), $urandom % 2, $urandom % 2);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule